// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The first is a table of 2-bit counters indexed directly by low bits of the branch PC. The second is a table of 2-bit counters indexed by the same low PC bits XORed with a register of recent branch outcomes. A third table of 2-bit up/down counters, also indexed by PC, acts as an arbiter. For each branch it picks whichever component has recently been more accurate there.

The fetch stage presents a PC on the lookup port. In the same cycle it receives the final direction, both component directions and the three table indices. It keeps these values with the branch. When the branch resolves, the pipeline returns the outcome on the training port together with the saved indices and component directions. The block then trains both component tables, adjusts the arbiter entry and shifts the outcome into the history register.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every component counter holds 01 (weakly not-taken), every arbiter counter holds 2, and the history register is all zeros. Every lookup therefore returns not-taken from both components, with the PC-indexed component selected.
- R2: The PC-indexed component uses index `pred_pc[BIM_W-1:0]`. PC bits above that index have no effect. A component predicts taken when bit 1 (the MSB) of its counter is 1.
- R3: On each training cycle, the addressed component counter counts up by one on a taken outcome and down by one on a not-taken outcome. It saturates at 3 and at 0.
- R4: The history component uses index `pred_pc[GSH_W-1:0] XOR hist`. After every training cycle, `hist` shifts left by one, the resolved outcome enters at bit 0 and the oldest bit is dropped.
- R5: The final direction equals the PC-indexed component's direction when the arbiter entry at `pred_pc[CH_W-1:0]` is 2 or 3. It equals the history component's direction when the entry is 0 or 1.
- R6: The arbiter entry counts up (saturating at 3) when only the PC-indexed component was correct. It counts down (saturating at 0) when only the history component was correct.
- R7: The arbiter entry is left unchanged when both components were correct or both were wrong.
- R8: Both component tables are trained on every training cycle, whichever component was selected.
- R9: Lookups are combinational from current state. A training cycle is visible to lookups from the next cycle on. Without `upd_valid`, no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Branch PC to look up |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | PC-indexed component direction |
| pred_gsh | output | 1 | History-indexed component direction |
| pred_bim_idx | output | BIM_W | Index into PC-indexed table |
| pred_gsh_idx | output | GSH_W | Index into history-indexed table |
| pred_ch_idx | output | CH_W | Index into arbiter table |
| upd_valid | input | 1 | Training strobe for a resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_bim_idx | input | BIM_W | Saved PC-indexed table index |
| upd_gsh_idx | input | GSH_W | Saved history-indexed table index |
| upd_ch_idx | input | CH_W | Saved arbiter index |
| upd_bim_pred | input | 1 | Saved PC-indexed component direction |
| upd_gsh_pred | input | 1 | Saved history-indexed component direction |

## Verification
The bench drives counters into both saturation limits. A design that wraps would flip a strongly-taken entry to not-taken. It also mixes outcome patterns until the two components disagree in both directions, so an arbiter that moves the wrong way or also moves on agreement would select the wrong component. Long runs of identical outcomes check the history register's shift direction and XOR indexing, since a reversed shift or a missing XOR shows up as a wrong index. Idle stretches and aliased PCs show whether state changes without a strobe and whether upper PC bits leak into the index.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_INC  = 2'd1,
        CTR_DEC  = 2'd2
    } ctr_op_e;

    typedef logic [1:0] ctr2_t;

    function automatic ctr2_t ctr_step(ctr2_t cur, ctr_op_e op);
        ctr2_t nxt;
        nxt = cur;
        if (op == CTR_INC && cur != 2'd3) nxt = cur + 2'd1;
        if (op == CTR_DEC && cur != 2'd0) nxt = cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/tp_ctr_bank.sv
module tp_ctr_bank
    import tp_pkg::*;
#(
    parameter int          IDX_W   = 6,
    parameter logic [1:0]  RST_VAL = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_op_e          wr_op
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_op);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ctr[rd_idx];

    // Saturation at the top and bottom of the counter range
    p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == CTR_INC && st_q.ctr[wr_idx] == 2'd3)
        |=> (st_q.ctr[$past(wr_idx)] == 2'd3));

    p_sat_bot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == CTR_DEC && st_q.ctr[wr_idx] == 2'd0)
        |=> (st_q.ctr[$past(wr_idx)] == 2'd0));

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == CTR_INC && st_q.ctr[wr_idx] != 2'd3)
        |=> (st_q.ctr[$past(wr_idx)] == $past(st_q.ctr[wr_idx]) + 2'd1));

    // Hold operation leaves the whole bank untouched
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == CTR_HOLD) |=> $stable(st_q));

    // No strobe, no change
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(st_q));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         taken,
    output logic [W-1:0] hist
);
    typedef struct packed {
        logic [W-1:0] bits;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.bits = {st_q.bits[W-2:0], taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.bits;

    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (hist[0] == $past(taken)) && (hist[W-1:1] == $past(hist[W-2:0])));

    p_hist_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd) |=> $stable(hist));

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
    import tp_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int BIM_W = 6,
    parameter int GSH_W = 6,
    parameter int CH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic             pred_bim,
    output logic             pred_gsh,
    output logic [BIM_W-1:0] pred_bim_idx,
    output logic [GSH_W-1:0] pred_gsh_idx,
    output logic [CH_W-1:0]  pred_ch_idx,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [BIM_W-1:0] upd_bim_idx,
    input  logic [GSH_W-1:0] upd_gsh_idx,
    input  logic [CH_W-1:0]  upd_ch_idx,
    input  logic             upd_bim_pred,
    input  logic             upd_gsh_pred
);
    localparam logic [1:0] COMP_RST = 2'b01;
    localparam logic [1:0] CH_RST   = 2'b10;

    logic [GSH_W-1:0] hist;
    logic [1:0]       bim_ctr, gsh_ctr, ch_ctr;
    ctr_op_e          dir_op, ch_op;
    logic             bim_ok, gsh_ok;
    logic             unused_bits;

    // Lookup side
    assign pred_bim_idx = pred_pc[BIM_W-1:0];
    assign pred_gsh_idx = pred_pc[GSH_W-1:0] ^ hist;
    assign pred_ch_idx  = pred_pc[CH_W-1:0];
    assign pred_bim     = bim_ctr[1];
    assign pred_gsh     = gsh_ctr[1];
    assign pred_taken   = ch_ctr[1] ? bim_ctr[1] : gsh_ctr[1];
    assign unused_bits  = ^{pred_pc, bim_ctr[0], gsh_ctr[0], ch_ctr[0]};

    // Training side
    always_comb begin
        bim_ok = (upd_bim_pred == upd_taken);
        gsh_ok = (upd_gsh_pred == upd_taken);
        dir_op = upd_taken ? CTR_INC : CTR_DEC;
        if (bim_ok && !gsh_ok)      ch_op = CTR_INC;
        else if (!bim_ok && gsh_ok) ch_op = CTR_DEC;
        else                        ch_op = CTR_HOLD;
    end

    tp_ctr_bank #(.IDX_W(BIM_W), .RST_VAL(COMP_RST)) u_bim (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_bim_idx),
        .rd_ctr (bim_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_bim_idx),
        .wr_op  (dir_op)
    );

    tp_ctr_bank #(.IDX_W(GSH_W), .RST_VAL(COMP_RST)) u_gsh (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_gsh_idx),
        .rd_ctr (gsh_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_gsh_idx),
        .wr_op  (dir_op)
    );

    tp_ctr_bank #(.IDX_W(CH_W), .RST_VAL(CH_RST)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_ch_idx),
        .rd_ctr (ch_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_ch_idx),
        .wr_op  (ch_op)
    );

    tp_ghist #(.W(GSH_W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd_valid),
        .taken (upd_taken),
        .hist  (hist)
    );

    // When the components agree, the arbiter cannot change the answer
    p_agree_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

    // Both components are trained on every strobe
    p_train_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (dir_op != CTR_HOLD));

    // Arbiter moves only on a one-sided result
    p_ch_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_bim_pred == upd_gsh_pred) |-> (ch_op == CTR_HOLD));

endmodule

// File: tb/tourney_pred_tb_top.sv
`timescale 1ns/1ps
module tourney_pred_tb_top;
    localparam int PC_W = 16;
    localparam int IW   = 6;
    localparam int N    = 1 << IW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken, pred_bim, pred_gsh;
    logic [IW-1:0]   pred_bim_idx, pred_gsh_idx, pred_ch_idx;
    logic            upd_valid = 1'b0, upd_taken = 1'b0;
    logic [IW-1:0]   upd_bim_idx = '0, upd_gsh_idx = '0, upd_ch_idx = '0;
    logic            upd_bim_pred = 1'b0, upd_gsh_pred = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0]    m_bim [N];
    logic [1:0]    m_gsh [N];
    logic [1:0]    m_ch  [N];
    logic [IW-1:0] m_hist;

    always #2.5 clk = ~clk;

    tourney_pred #(.PC_W(PC_W), .BIM_W(IW), .GSH_W(IW), .CH_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
        .pred_bim_idx(pred_bim_idx), .pred_gsh_idx(pred_gsh_idx), .pred_ch_idx(pred_ch_idx),
        .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_bim_idx(upd_bim_idx), .upd_gsh_idx(upd_gsh_idx), .upd_ch_idx(upd_ch_idx),
        .upd_bim_pred(upd_bim_pred), .upd_gsh_pred(upd_gsh_pred)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] sat(input logic [1:0] c, input bit up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    // Compare every lookup output against the model
    task automatic look(input logic [PC_W-1:0] pc, input string tag);
        logic [IW-1:0] bi, gi, ci;
        bit eb, eg, et;
        @(negedge clk);
        pred_pc = pc;
        #1;
        bi = pc[IW-1:0];
        gi = pc[IW-1:0] ^ m_hist;
        ci = pc[IW-1:0];
        eb = m_bim[bi][1];
        eg = m_gsh[gi][1];
        et = (m_ch[ci] >= 2) ? eb : eg;
        chk({tag, " R2 bim_idx"}, pred_bim_idx, bi);
        chk({tag, " R4 gsh_idx"}, pred_gsh_idx, gi);
        chk({tag, " R2 ch_idx"}, pred_ch_idx, ci);
        chk({tag, " R3 bim dir"}, pred_bim, eb);
        chk({tag, " R8 gsh dir"}, pred_gsh, eg);
        chk({tag, " R5 final"}, pred_taken, et);
    endtask

    // Lookup, then train with the model's own saved values
    task automatic step(input logic [PC_W-1:0] pc, input bit taken, input string tag);
        logic [IW-1:0] bi, gi;
        bit eb, eg, c1, c2;
        look(pc, tag);
        bi = pc[IW-1:0];
        gi = pc[IW-1:0] ^ m_hist;
        eb = m_bim[bi][1];
        eg = m_gsh[gi][1];
        @(negedge clk);
        upd_valid = 1'b1; upd_taken = taken;
        upd_bim_idx = bi; upd_gsh_idx = gi; upd_ch_idx = bi;
        upd_bim_pred = eb; upd_gsh_pred = eg;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        c1 = (eb == taken);
        c2 = (eg == taken);
        m_bim[bi] = sat(m_bim[bi], taken);
        m_gsh[gi] = sat(m_gsh[gi], taken);
        if (c1 && !c2) m_ch[bi] = sat(m_ch[bi], 1'b1);   // R6
        if (!c1 && c2) m_ch[bi] = sat(m_ch[bi], 1'b0);   // R6, both-equal holds: R7
        m_hist = {m_hist[IW-2:0], taken};
    endtask

    task automatic t_reset;
        look(16'h0000, "R1 reset");
        look(16'h0025, "R1 reset");
        chk("R1 reset taken", pred_taken, 0);
        chk("R1 reset gsh_idx hist zero", pred_gsh_idx, 6'h25);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 5; i++) step(16'h0011, 1'b1, "R3 up");
        chk("R3 strong taken", pred_bim, 1);
        for (int i = 0; i < 5; i++) step(16'h0011, 1'b0, "R3 down");
        look(16'h0011, "R3 floor");
        chk("R3 floor not-taken", pred_bim, 0);
        step(16'h0011, 1'b1, "R3 after floor");
        look(16'h0011, "R3 one above floor");
        chk("R3 one above floor still not-taken", pred_bim, 0);
    endtask

    task automatic t_alias;
        step(16'h0107, 1'b1, "R2 alias train");
        step(16'hFF07, 1'b1, "R2 alias train");
        look(16'h4007, "R2 alias read");
        chk("R2 upper PC bits ignored", pred_bim, 1);
    endtask

    task automatic t_history;
        bit pat [8] = '{1, 0, 1, 1, 0, 0, 1, 1};
        for (int i = 0; i < 8; i++) step(16'(8'h30 + i), pat[i], "R4 hist");
        for (int i = 0; i < 6; i++) step(16'h0030, 1'b1, "R4 run");
        look(16'h0030, "R4 all-ones hist");
        chk("R4 gsh_idx with all-ones history", pred_gsh_idx, 6'h30 ^ 6'h3F);
    endtask

    task automatic t_chooser;
        for (int r = 0; r < 12; r++) begin
            step(16'h0020, r[0], "R6 alt");
            step(16'h0021, 1'b1, "R6 bias");
            step(16'h0022, (r % 3) == 0, "R7 mix");
        end
        for (int r = 0; r < 10; r++) begin
            step(16'h0020, 1'b1, "R6 settle");
            step(16'h0020, 1'b1, "R5 select");
            step(16'h0023, 1'b0, "R7 both right");
        end
    endtask

    task automatic t_idle;
        step(16'h003A, 1'b1, "R9 train");
        look(16'h003A, "R9 next cycle");
        chk("R9 update visible next cycle", pred_bim, 1);
        repeat (20) @(posedge clk);
        look(16'h003A, "R9 after idle");
        look(16'h0011, "R9 after idle");
        chk("R9 idle leaves history", pred_gsh_idx, 6'h11 ^ m_hist);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_bim[i] = 2'b01; m_gsh[i] = 2'b01; m_ch[i] = 2'b10;
        end
        m_hist = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_saturate();
        t_alias();
        t_history();
        t_chooser();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule